// File: doc/BRIEF.md
# Stepwise Performance-Level Sequencer

This block manages the operating point of one processing core. The core has a small set of discrete performance levels. Each level ties one supply rail to one clock frequency, and only those pairings are legal. At the start of every workload tick, a selector compares the load measured for that tick against a set of ascending thresholds. The result is the target level. The selector keeps only the most recent result, including results that arrive while a change is in progress.

When the target differs from the current level, a sequencer moves the core one level toward it. It runs a fixed series of phases:

1. Gate the core clock.
2. Switch the one-hot rail enables.
3. Wait for the supply net to charge.
4. Drive the new frequency code and wait for lock or a timeout.
5. Release the clock.

A programmable dwell follows every step. A request that spans several levels is therefore carried out as separate single-level hops, and each frequency jump stays small.

Top module: `pwr_level_seq`

## Requirements
- R1: There are 2^LVL_W levels (four by default). Level code n drives rail enable bit n alone and frequency select code n.
- R2: On a cycle with `tick_i` high, the target is set to the number of thresholds that `load_i` is greater than or equal to. Threshold k sits in bits [16k+15:16k] of `thr_i`, and the thresholds ascend. The target is registered at that edge, and the last tick always wins, including ticks that arrive during a change.
- R3: A step runs in this order. The clock is gated for one cycle. The rail switches for one cycle. Pre-charge lasts `pre_wait_i` cycles (at least one). Frequency select follows, then a one-cycle clock release. `clk_en_o` is low exactly from the gate phase through the frequency phase.
- R4: `rail_sel_o` always has exactly one bit set, and it changes only while `clk_en_o` is low.
- R5: The frequency phase ends in the first cycle that `pll_lock_i` is high, or after `lock_wait_i` cycles (at least one), whichever comes first. `freq_sel_o` changes only while the clock is gated.
- R6: A change across several levels is carried out one level per step. Every step is followed by a dwell of `dwell_i` cycles (at least one) before the target is compared again.
- R7: `level_o` updates at the end of the clock-release phase and changes by exactly one level per step.
- R8: `busy_o` is high from the clock-gate phase through the end of the dwell that follows the step, and is low otherwise.
- R9: After reset, the level is 0, `rail_sel_o` is 0001, `freq_sel_o` is 0, `clk_en_o` is high and `busy_o` is low.
- R10: A target equal to the current level starts no sequence. The clock stays enabled and `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse marking a new workload tick |
| load_i | input | LOAD_W | Load measured for the tick |
| thr_i | input | (2^LVL_W-1)*LOAD_W | Ascending level thresholds, threshold k in slice k |
| pre_wait_i | input | CNT_W | Pre-charge length in cycles |
| lock_wait_i | input | CNT_W | Maximum frequency-lock wait in cycles |
| dwell_i | input | CNT_W | Dwell between steps in cycles |
| pll_lock_i | input | 1 | Clock generator lock indication |
| clk_en_o | output | 1 | Core clock enable |
| rail_sel_o | output | 2^LVL_W | One-hot supply rail header enables |
| freq_sel_o | output | LVL_W | Frequency code for the clock generator |
| level_o | output | LVL_W | Level currently in effect |
| busy_o | output | 1 | A step or its dwell is in progress |

## Verification
A wrong phase register shows up at the ports within one cycle. It appears as `clk_en_o` released early or held low, or as a rail or frequency code that changes while the clock runs. A miscounting phase timer stretches or shortens a clock-gated window. The bench sees this on the cycle the window should have closed. A wrong step register or target register shows as a rail code, a frequency code or a final level that differs from the reference model at the first edge after the bad value is used. The model is compared with every output on every clock, so none of these faults stays hidden for more than one cycle past its first visible effect.

// File: rtl/pls_pkg.sv
package pls_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_GATE,
    PH_RAIL,
    PH_PRECHG,
    PH_FREQ,
    PH_UNGATE,
    PH_DWELL
  } phase_e;
endpackage

// File: rtl/pls_lvl_select.sv
module pls_lvl_select #(
  parameter int LVL_W  = 2,
  parameter int LOAD_W = 16
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 tick_i,
  input  logic [LOAD_W-1:0]                    load_i,
  input  logic [((1<<LVL_W)-1)*LOAD_W-1:0]     thr_i,
  output logic [LVL_W-1:0]                     tgt_o
);
  localparam int NUM_THR = (1 << LVL_W) - 1;

  logic [NUM_THR-1:0] above;
  logic [LVL_W-1:0]   tgt_d, tgt_q;

  for (genvar gi = 0; gi < NUM_THR; gi++) begin : g_cmp
    assign above[gi] = load_i >= thr_i[gi*LOAD_W +: LOAD_W];
  end

  always_comb begin
    tgt_d = '0;
    for (int i = 0; i < NUM_THR; i++) tgt_d = tgt_d + LVL_W'(above[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tgt_q <= '0;
    else if (tick_i) tgt_q <= tgt_d;
  end

  assign tgt_o = tgt_q;

  assert_tgt_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tgt_q) |-> $past(tick_i));
endmodule

// File: rtl/pls_timer.sv
module pls_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  // a phase lasts max(len,1) cycles
  assign last_o = ((CNT_W+1)'(cnt_q) + (CNT_W+1)'(1)) >= (CNT_W+1)'(len_i);
endmodule

// File: rtl/pls_step_fsm.sv
module pls_step_fsm
  import pls_pkg::*;
#(
  parameter int LVL_W = 2,
  parameter int CNT_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [LVL_W-1:0]      tgt_i,
  input  logic [CNT_W-1:0]      pre_wait_i,
  input  logic [CNT_W-1:0]      lock_wait_i,
  input  logic [CNT_W-1:0]      dwell_i,
  input  logic                  pll_lock_i,
  output logic                  clk_en_o,
  output logic [(1<<LVL_W)-1:0] rail_sel_o,
  output logic [LVL_W-1:0]      freq_sel_o,
  output logic [LVL_W-1:0]      level_o,
  output logic                  busy_o
);
  localparam int NUM_LVL = 1 << LVL_W;

  phase_e               state_q, state_d;
  logic [LVL_W-1:0]     step_q, step_nxt, lvl_q, freq_q;
  logic [NUM_LVL-1:0]   rail_q;
  logic [CNT_W-1:0]     len;
  logic                 last;

  always_comb begin
    unique case (state_q)
      PH_PRECHG: len = pre_wait_i;
      PH_FREQ:   len = lock_wait_i;
      PH_DWELL:  len = dwell_i;
      default:   len = '0;
    endcase
  end

  pls_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_d != state_q),
    .len_i  (len),
    .last_o (last)
  );

  assign step_nxt = (tgt_i > lvl_q) ? lvl_q + 1'b1 : lvl_q - 1'b1;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE:   if (tgt_i != lvl_q)       state_d = PH_GATE;
      PH_GATE:                             state_d = PH_RAIL;
      PH_RAIL:                             state_d = PH_PRECHG;
      PH_PRECHG: if (last)                 state_d = PH_FREQ;
      PH_FREQ:   if (pll_lock_i || last)   state_d = PH_UNGATE;
      PH_UNGATE:                           state_d = PH_DWELL;
      PH_DWELL:  if (last)                 state_d = PH_IDLE;
      default:                             state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      step_q  <= '0;
      lvl_q   <= '0;
      freq_q  <= '0;
      rail_q  <= NUM_LVL'(1);
    end else begin
      state_q <= state_d;
      if (state_q == PH_IDLE && state_d == PH_GATE) step_q <= step_nxt;
      if (state_q == PH_GATE)                       rail_q <= NUM_LVL'(1) << step_q;
      if (state_q == PH_PRECHG && state_d == PH_FREQ) freq_q <= step_q;
      if (state_q == PH_UNGATE)                     lvl_q  <= step_q;
    end
  end

  assign clk_en_o   = !(state_q inside {PH_GATE, PH_RAIL, PH_PRECHG, PH_FREQ});
  assign busy_o     = state_q != PH_IDLE;
  assign rail_sel_o = rail_q;
  assign freq_sel_o = freq_q;
  assign level_o    = lvl_q;

  assert_rail_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rail_sel_o) == 1);
  assert_rail_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rail_sel_o) |-> !clk_en_o);
  assert_freq_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(freq_sel_o) |-> !clk_en_o);
  assert_level_single_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lvl_q) |-> ((int'(lvl_q) - int'($past(lvl_q)) == 1) ||
                         (int'(lvl_q) - int'($past(lvl_q)) == -1)));
  assert_busy_when_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_o |-> busy_o);
endmodule

// File: rtl/pwr_level_seq.sv
module pwr_level_seq #(
  parameter int LVL_W  = 2,
  parameter int LOAD_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              tick_i,
  input  logic [LOAD_W-1:0]                 load_i,
  input  logic [((1<<LVL_W)-1)*LOAD_W-1:0]  thr_i,
  input  logic [CNT_W-1:0]                  pre_wait_i,
  input  logic [CNT_W-1:0]                  lock_wait_i,
  input  logic [CNT_W-1:0]                  dwell_i,
  input  logic                              pll_lock_i,
  output logic                              clk_en_o,
  output logic [(1<<LVL_W)-1:0]             rail_sel_o,
  output logic [LVL_W-1:0]                  freq_sel_o,
  output logic [LVL_W-1:0]                  level_o,
  output logic                              busy_o
);
  logic [LVL_W-1:0] tgt;

  pls_lvl_select #(.LVL_W(LVL_W), .LOAD_W(LOAD_W)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .load_i (load_i),
    .thr_i  (thr_i),
    .tgt_o  (tgt)
  );

  pls_step_fsm #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tgt_i       (tgt),
    .pre_wait_i  (pre_wait_i),
    .lock_wait_i (lock_wait_i),
    .dwell_i     (dwell_i),
    .pll_lock_i  (pll_lock_i),
    .clk_en_o    (clk_en_o),
    .rail_sel_o  (rail_sel_o),
    .freq_sel_o  (freq_sel_o),
    .level_o     (level_o),
    .busy_o      (busy_o)
  );
endmodule

// File: tb/sim_pwr_level_seq.sv
`timescale 1ns/1ps
module sim_pwr_level_seq;
  localparam int LVL_W = 2, LOAD_W = 16, CNT_W = 8;

  logic clk = 1'b0, rst_ni = 1'b0, tick = 1'b0, lock = 1'b0;
  logic [LOAD_W-1:0] load = '0;
  logic [3*LOAD_W-1:0] thr;
  logic [CNT_W-1:0] pre_w = 8'd3, lock_w = 8'd5, dwell_w = 8'd4;
  logic clk_en, busy;
  logic [3:0] rail;
  logic [1:0] freq, level;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign thr = {16'd300, 16'd200, 16'd100};

  pwr_level_seq #(.LVL_W(LVL_W), .LOAD_W(LOAD_W), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .load_i(load), .thr_i(thr),
    .pre_wait_i(pre_w), .lock_wait_i(lock_w), .dwell_i(dwell_w), .pll_lock_i(lock),
    .clk_en_o(clk_en), .rail_sel_o(rail), .freq_sel_o(freq), .level_o(level), .busy_o(busy)
  );

  // behavioural reference: ph 0 idle,1 gate,2 rail,3 pre,4 freq,5 ungate,6 dwell
  int m_ph, m_cnt, m_lvl, m_tgt, m_step, m_freq, m_rail;

  function automatic int sel_level(int ld);
    int n = 0;
    if (ld >= 100) n++;
    if (ld >= 200) n++;
    if (ld >= 300) n++;
    return n;
  endfunction

  function automatic bit reached(int c, int len);
    return (c + 1) >= len;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_cnt = 0; m_lvl = 0; m_tgt = 0; m_step = 0; m_freq = 0; m_rail = 1;
    end else begin
      case (m_ph)
        0: if (m_tgt != m_lvl) begin
             m_step = (m_tgt > m_lvl) ? m_lvl + 1 : m_lvl - 1;
             m_ph = 1;
           end
        1: begin m_rail = 1 << m_step; m_ph = 2; end
        2: begin m_ph = 3; m_cnt = 0; end
        3: if (reached(m_cnt, int'(pre_w))) begin m_ph = 4; m_freq = m_step; m_cnt = 0; end
           else m_cnt++;
        4: if (lock || reached(m_cnt, int'(lock_w))) m_ph = 5;
           else m_cnt++;
        5: begin m_lvl = m_step; m_ph = 6; m_cnt = 0; end
        default: if (reached(m_cnt, int'(dwell_w))) m_ph = 0;
                 else m_cnt++;
      endcase
      if (tick) m_tgt = sel_level(int'(load));
    end
  end

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk("R3 clk_en", int'(clk_en), (m_ph >= 1 && m_ph <= 4) ? 0 : 1);
      chk("R4 rail_sel", int'(rail), m_rail);
      chk("R5 freq_sel", int'(freq), m_freq);
      chk("R7 level", int'(level), m_lvl);
      chk("R8 busy", int'(busy), (m_ph != 0) ? 1 : 0);
    end
  end

  int gated;
  always @(negedge clk) if (rst_ni && !clk_en) gated++;

  task automatic do_tick(int ld);
    @(negedge clk); load = LOAD_W'(ld); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9 reset state, R1 level 0 maps to rail bit 0
    chk("R9 level", int'(level), 0);
    chk("R9 rail", int'(rail), 1);
    chk("R1 freq", int'(freq), 0);
    chk("R9 clk_en", int'(clk_en), 1);
    chk("R9 busy", int'(busy), 0);

    // R10 target equal to level: nothing starts
    do_tick(50);
    gated = 0;
    repeat (10) @(negedge clk);
    chk("R10 no gating", gated, 0);
    chk("R10 busy", int'(busy), 0);

    // R6 multi-level change, 0 -> 3 in single steps; each step gated 1+1+3+5 = 10 cycles
    gated = 0;
    do_tick(350);
    repeat (120) @(negedge clk);
    chk("R6 final level", int'(level), 3);
    chk("R1 rail of level 3", int'(rail), 8);
    chk("R3 gated cycles", gated, 30);

    // R2 ticks during busy: last one wins (250 -> level 2)
    do_tick(0);
    repeat (3) @(negedge clk);
    do_tick(150);
    do_tick(250);
    repeat (120) @(negedge clk);
    chk("R2 latest tick", int'(level), 2);

    // R5 early lock: 2 -> 0, each step gated 1+1+3+1 = 6 cycles
    lock = 1'b1;
    gated = 0;
    do_tick(10);
    repeat (80) @(negedge clk);
    chk("R5 early lock level", int'(level), 0);
    chk("R5 early lock gated", gated, 12);
    lock = 1'b0;

    // zero lengths clamp to one cycle: 1+1+1+1 = 4 gated
    pre_w = '0; lock_w = '0; dwell_w = '0;
    gated = 0;
    do_tick(120);
    repeat (30) @(negedge clk);
    chk("R3 min phase gated", gated, 4);
    chk("R7 level one", int'(level), 1);
    chk("R4 rail of level 1", int'(rail), 2);

    done = 1;
    report();
    $finish;
  end

  initial begin
    #200000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    done = 1;
    report();
    $finish;
  end
endmodule